// File: doc/BRIEF.md
# Adaptive Miss Request Mode Selector

This block sits in one shared-cache partition and picks the delivery mode for each outgoing miss request. A peer-to-peer request is broadcast straight to the other on-chip partitions. A mediated request goes first to a serialising gateway, which handles any broadcast. The choice is learned while the chip runs. Two saturating history counters, one for instruction misses and one for data misses, track whether recent misses were filled by another partition or by memory. Each counter is compared with its own software-programmable threshold.

A peer-to-peer attempt can fail for two reasons. No other partition may hold the line with the access rights that are needed, or the attempt may collide with another peer-to-peer request to the same line. In either case the block issues one retry, one cycle later, and that retry always takes the mediated path. A request that failed on the mediated path is never retried. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` goes high.

Top module: `miss_mode_sel`

## Requirements
- R1: After reset both history counters are zero, both thresholds equal THR_RST (default 0), every miss is steered to the mediated path (`mode_p2p` = 0) and `retry_vld` is 0.
- R2: While `miss_vld` is 1 and `miss_is_instr` is 0 (a data miss), `mode_p2p` is 1 (peer-to-peer) exactly when the data counter is strictly greater than the data threshold, and 0 (mediated) otherwise. It is combinational in the same cycle.
- R3: While `miss_vld` is 1 and `miss_is_instr` is 1 (an instruction miss), `mode_p2p` follows the same rule using the instruction counter and the instruction threshold.
- R4: A completion (`cmpl_vld` = 1) with `cmpl_from_peer` = 1 increments the counter of its class (`cmpl_is_instr`: 0 data, 1 instruction) on the next edge. The counter saturates at 2^CNT_W-1.
- R5: A completion with `cmpl_from_peer` = 0 (filled from memory) decrements the counter of its class on the next edge. The counter holds at 0.
- R6: A completion of one class leaves the counter of the other class unchanged.
- R7: A threshold write (`thr_wr_en` = 1, with `thr_wr_cls` 0 for data and 1 for instruction) loads `thr_wr_val` into that class's threshold only. The new value governs the mode from the next cycle on.
- R8: A failed request with `fail_was_p2p` = 1 and `fail_cause` = 1 (conflict with another peer-to-peer request) produces `retry_vld` = 1 on the next cycle, with `retry_tag` equal to `fail_tag` and `retry_cause` equal to 1. The retry is always a mediated request.
- R9: A failed request with `fail_was_p2p` = 1 and `fail_cause` = 0 (no partition holds the line with the needed rights) produces the same one-cycle retry, with `retry_cause` equal to 0.
- R10: A failed request with `fail_was_p2p` = 0 (already mediated, including a retry) produces no retry. In any cycle not preceded by a peer-to-peer failure, `retry_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_cls | input | 1 | Threshold class: 0 data, 1 instruction |
| thr_wr_val | input | CNT_W | Threshold value to load |
| miss_vld | input | 1 | Miss request awaiting a mode |
| miss_is_instr | input | 1 | Miss class: 0 data, 1 instruction |
| mode_p2p | output | 1 | 1 peer-to-peer, 0 mediated (qualified by miss_vld) |
| cmpl_vld | input | 1 | Miss completion report |
| cmpl_is_instr | input | 1 | Completion class: 0 data, 1 instruction |
| cmpl_from_peer | input | 1 | 1 filled by another partition, 0 filled from memory |
| fail_vld | input | 1 | Failure report for an issued request |
| fail_was_p2p | input | 1 | The failed request used the peer-to-peer path |
| fail_cause | input | 1 | 1 conflict, 0 insufficient rights |
| fail_tag | input | TAG_W | Identifier of the failed request |
| retry_vld | output | 1 | Mediated retry request |
| retry_cause | output | 1 | Cause copied from the failure |
| retry_tag | output | TAG_W | Identifier copied from the failure |

## Verification
The counters can only be seen through the mode output, so the hardest cases are saturation and the floor at zero. A counter that wrapped instead of saturating would often produce the same mode. The bench drives a counter well past its ceiling with a threshold one step below it. A single memory fill must then flip the mode back to mediated. It also drains a counter below zero and sets the threshold to 0, where a wrapped counter would wrongly read as peer-to-peer. Threshold writes are placed right before a mode check to pin down the one-cycle timing of R7.

// File: rtl/mms_pkg.sv
package mms_pkg;
  typedef enum logic {
    CLS_DATA  = 1'b0,
    CLS_INSTR = 1'b1
  } miss_cls_e;

  typedef enum logic {
    CAUSE_NORIGHTS = 1'b0,
    CAUSE_CONFLICT = 1'b1
  } fail_cause_e;

  localparam int unsigned NUM_CLS = 2;
endpackage

// File: rtl/mms_rst_sync.sv
module mms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mms_hist.sv
// One history counter with its threshold for a single miss class.
module mms_hist #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned THR_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             upd_peer,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_wd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] thr,
  output logic             use_p2p
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (upd_en) begin
      if (upd_peer && cnt_q != CNT_MAX) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end else if (!upd_peer && cnt_q != CNT_MIN) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end
    thr_d = thr_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= CNT_W'(THR_RST);
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (thr_we) thr_q <= thr_d;
    end
  end

  assign cnt     = cnt_q;
  assign thr     = thr_q;
  assign use_p2p = (cnt_q > thr_q);
endmodule

// File: rtl/mms_retry.sv
// Turns a failed peer-to-peer attempt into one mediated retry.
module mms_retry #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_vld,
  input  logic             fail_was_p2p,
  input  logic             fail_cause,
  input  logic [TAG_W-1:0] fail_tag,
  output logic             retry_vld,
  output logic             retry_cause,
  output logic [TAG_W-1:0] retry_tag
);
  logic             vld_q, vld_d;
  logic             cause_q, cause_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             load_en;

  always_comb begin
    vld_d   = fail_vld & fail_was_p2p;
    load_en = vld_d;
    cause_d = fail_cause;
    tag_d   = fail_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      cause_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        cause_q <= cause_d;
        tag_q   <= tag_d;
      end
    end
  end

  assign retry_vld   = vld_q;
  assign retry_cause = cause_q;
  assign retry_tag   = tag_q;
endmodule

// File: rtl/miss_mode_sel.sv
module miss_mode_sel #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned THR_RST = 0,
  parameter int unsigned TAG_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr_en,
  input  logic             thr_wr_cls,
  input  logic [CNT_W-1:0] thr_wr_val,
  input  logic             miss_vld,
  input  logic             miss_is_instr,
  output logic             mode_p2p,
  input  logic             cmpl_vld,
  input  logic             cmpl_is_instr,
  input  logic             cmpl_from_peer,
  input  logic             fail_vld,
  input  logic             fail_was_p2p,
  input  logic             fail_cause,
  input  logic [TAG_W-1:0] fail_tag,
  output logic             retry_vld,
  output logic             retry_cause,
  output logic [TAG_W-1:0] retry_tag
);
  import mms_pkg::*;

  logic                            rst_sync_n;
  logic [NUM_CLS-1:0][CNT_W-1:0]   hist_cnt;
  logic [NUM_CLS-1:0][CNT_W-1:0]   hist_thr;
  logic [NUM_CLS-1:0]              hist_p2p;

  mms_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic upd_en, thr_we;
    assign upd_en = cmpl_vld  && (cmpl_is_instr == c[0]);
    assign thr_we = thr_wr_en && (thr_wr_cls == c[0]);

    mms_hist #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_hist (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .upd_en   (upd_en),
      .upd_peer (cmpl_from_peer),
      .thr_we   (thr_we),
      .thr_wd   (thr_wr_val),
      .cnt      (hist_cnt[c]),
      .thr      (hist_thr[c]),
      .use_p2p  (hist_p2p[c])
    );
  end

  assign mode_p2p = miss_vld && (miss_is_instr ? hist_p2p[CLS_INSTR]
                                               : hist_p2p[CLS_DATA]);

  mms_retry #(.TAG_W(TAG_W)) u_retry (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fail_vld     (fail_vld),
    .fail_was_p2p (fail_was_p2p),
    .fail_cause   (fail_cause),
    .fail_tag     (fail_tag),
    .retry_vld    (retry_vld),
    .retry_cause  (retry_cause),
    .retry_tag    (retry_tag)
  );
endmodule

// File: rtl/mms_chk.sv
module mms_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned TAG_W = 6
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  miss_vld,
  input logic                  miss_is_instr,
  input logic                  mode_p2p,
  input logic                  cmpl_vld,
  input logic                  cmpl_is_instr,
  input logic                  cmpl_from_peer,
  input logic                  fail_vld,
  input logic                  fail_was_p2p,
  input logic                  fail_cause,
  input logic [TAG_W-1:0]      fail_tag,
  input logic                  retry_vld,
  input logic                  retry_cause,
  input logic [TAG_W-1:0]      retry_tag,
  input logic [1:0][CNT_W-1:0] hist_cnt,
  input logic [1:0][CNT_W-1:0] hist_thr
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar c = 0; c < 2; c++) begin : g_c
    // R4
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmpl_vld && cmpl_is_instr == c[0] && cmpl_from_peer && hist_cnt[c] != CMAX)
      |=> hist_cnt[c] == CNT_W'($past(hist_cnt[c]) + 1'b1));
    // R4
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmpl_vld && cmpl_is_instr == c[0] && cmpl_from_peer && hist_cnt[c] == CMAX)
      |=> $stable(hist_cnt[c]));
    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmpl_vld && cmpl_is_instr == c[0] && !cmpl_from_peer && hist_cnt[c] != '0)
      |=> hist_cnt[c] == CNT_W'($past(hist_cnt[c]) - 1'b1));
    // R5
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cmpl_vld && cmpl_is_instr == c[0] && !cmpl_from_peer && hist_cnt[c] == '0)
      |=> hist_cnt[c] == '0);
    // R6
    cnt_iso_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!cmpl_vld || cmpl_is_instr != c[0]) |=> $stable(hist_cnt[c]));
    // R2 R3
    mode_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (miss_vld && miss_is_instr == c[0]) |-> mode_p2p == (hist_cnt[c] > hist_thr[c]));
  end

  // R8 R9
  retry_issue_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fail_vld && fail_was_p2p) |=>
      (retry_vld && retry_tag == $past(fail_tag) && retry_cause == $past(fail_cause)));
  // R10
  no_retry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fail_vld && fail_was_p2p) |=> !retry_vld);
  // R2
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !miss_vld |-> !mode_p2p);
endmodule

bind miss_mode_sel mms_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .miss_vld       (miss_vld),
  .miss_is_instr  (miss_is_instr),
  .mode_p2p       (mode_p2p),
  .cmpl_vld       (cmpl_vld),
  .cmpl_is_instr  (cmpl_is_instr),
  .cmpl_from_peer (cmpl_from_peer),
  .fail_vld       (fail_vld),
  .fail_was_p2p   (fail_was_p2p),
  .fail_cause     (fail_cause),
  .fail_tag       (fail_tag),
  .retry_vld      (retry_vld),
  .retry_cause    (retry_cause),
  .retry_tag      (retry_tag),
  .hist_cnt       (hist_cnt),
  .hist_thr       (hist_thr)
);

// File: tb/miss_mode_sel_tb_top.sv
module miss_mode_sel_tb_top;
  localparam int CNT_W = 4;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic thr_wr_en, thr_wr_cls;
  logic [CNT_W-1:0] thr_wr_val;
  logic miss_vld, miss_is_instr, mode_p2p;
  logic cmpl_vld, cmpl_is_instr, cmpl_from_peer;
  logic fail_vld, fail_was_p2p, fail_cause;
  logic [TAG_W-1:0] fail_tag, retry_tag;
  logic retry_vld, retry_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  miss_mode_sel #(.CNT_W(CNT_W), .THR_RST(0), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .thr_wr_en(thr_wr_en), .thr_wr_cls(thr_wr_cls), .thr_wr_val(thr_wr_val),
    .miss_vld(miss_vld), .miss_is_instr(miss_is_instr), .mode_p2p(mode_p2p),
    .cmpl_vld(cmpl_vld), .cmpl_is_instr(cmpl_is_instr), .cmpl_from_peer(cmpl_from_peer),
    .fail_vld(fail_vld), .fail_was_p2p(fail_was_p2p), .fail_cause(fail_cause),
    .fail_tag(fail_tag), .retry_vld(retry_vld), .retry_cause(retry_cause),
    .retry_tag(retry_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_mode(input logic instr, input int exp, input string req);
    miss_vld = 1'b1; miss_is_instr = instr;
    #1;
    check(req, int'(mode_p2p), exp);
    miss_vld = 1'b0;
  endtask

  task automatic wr_thr(input logic cls, input int val);
    @(negedge clk);
    thr_wr_en = 1'b1; thr_wr_cls = cls; thr_wr_val = CNT_W'(val);
    @(negedge clk);
    thr_wr_en = 1'b0;
  endtask

  task automatic cmpl(input logic instr, input logic peer, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmpl_vld = 1'b1; cmpl_is_instr = instr; cmpl_from_peer = peer;
    end
    @(negedge clk);
    cmpl_vld = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 retry idle", int'(retry_vld), 0);
    chk_mode(1'b0, 0, "R1 data mediated");
    chk_mode(1'b1, 0, "R1 instr mediated");
  endtask

  task automatic t_data_thr;
    wr_thr(1'b0, 2);
    cmpl(1'b0, 1'b1, 2);
    chk_mode(1'b0, 0, "R2 cnt2 thr2 mediated");
    cmpl(1'b0, 1'b1, 1);
    chk_mode(1'b0, 1, "R2 cnt3 thr2 p2p");
    chk_mode(1'b1, 0, "R6 instr untouched by data");
  endtask

  task automatic t_instr_thr;
    wr_thr(1'b1, 1);
    cmpl(1'b1, 1'b1, 2);
    chk_mode(1'b1, 1, "R3 instr cnt2 thr1 p2p");
    chk_mode(1'b0, 1, "R6 data untouched by instr");
    cmpl(1'b1, 1'b0, 1);
    chk_mode(1'b1, 0, "R5 instr dec to 1 mediated");
  endtask

  task automatic t_saturate;
    wr_thr(1'b0, 14);
    cmpl(1'b0, 1'b1, 20);
    chk_mode(1'b0, 1, "R4 saturated at 15 p2p");
    cmpl(1'b0, 1'b0, 1);
    chk_mode(1'b0, 0, "R4 15-1=14 mediated");
  endtask

  task automatic t_floor;
    cmpl(1'b1, 1'b0, 5);
    wr_thr(1'b1, 0);
    chk_mode(1'b1, 0, "R5 floor at 0 mediated");
    cmpl(1'b1, 1'b1, 1);
    chk_mode(1'b1, 1, "R5 0+1 p2p");
  endtask

  task automatic t_thr_timing;
    // data counter is 14, data threshold 14
    @(negedge clk);
    thr_wr_en = 1'b1; thr_wr_cls = 1'b0; thr_wr_val = 4'd13;
    chk_mode(1'b0, 0, "R7 old thr before edge");
    @(negedge clk);
    thr_wr_en = 1'b0;
    chk_mode(1'b0, 1, "R7 new thr next cycle");
    chk_mode(1'b1, 1, "R7 instr thr unchanged");
  endtask

  task automatic t_retry;
    @(negedge clk);
    fail_vld = 1'b1; fail_was_p2p = 1'b1; fail_cause = 1'b1; fail_tag = 6'd37;
    @(negedge clk);
    fail_vld = 1'b0;
    check("R8 retry vld", int'(retry_vld), 1);
    check("R8 retry tag", int'(retry_tag), 37);
    check("R8 retry cause", int'(retry_cause), 1);
    fail_vld = 1'b1; fail_was_p2p = 1'b1; fail_cause = 1'b0; fail_tag = 6'd9;
    @(negedge clk);
    fail_vld = 1'b0;
    check("R9 retry vld", int'(retry_vld), 1);
    check("R9 retry tag", int'(retry_tag), 9);
    check("R9 retry cause", int'(retry_cause), 0);
    fail_vld = 1'b1; fail_was_p2p = 1'b0; fail_cause = 1'b1; fail_tag = 6'd50;
    @(negedge clk);
    fail_vld = 1'b0;
    check("R10 mediated fail no retry", int'(retry_vld), 0);
    @(negedge clk);
    check("R10 idle no retry", int'(retry_vld), 0);
  endtask

  initial begin
    #(5ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    thr_wr_en = 0; thr_wr_cls = 0; thr_wr_val = '0;
    miss_vld = 0; miss_is_instr = 0;
    cmpl_vld = 0; cmpl_is_instr = 0; cmpl_from_peer = 0;
    fail_vld = 0; fail_was_p2p = 0; fail_cause = 0; fail_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_data_thr;
    t_instr_thr;
    t_saturate;
    t_floor;
    t_thr_timing;
    t_retry;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule